// File: doc/BRIEF.md
# Programmable External Bus Cycle Generator

This block turns single requests from a processor-side port into timed cycles on an asynchronous external memory bus. The bus is split into chip-select zones, and the zone is decoded from the top address bits. Each access runs through three phases. In the lead phase the chip select and address settle. In the active phase the read or write strobe is asserted. In the trail phase the chip select is still held but the strobe is released. Every zone keeps its own lead, active and trail lengths, one set for reads and one for writes. Each zone also has a doubling flag, a ready-enable bit and a ready-mode bit.

All phase lengths count ticks of a timing clock. That clock runs at the system clock rate or at half that rate. A zone can let an external ready line stretch its active phase. Ready is sampled either directly or through a two-flop synchronizer. A bank rule names one zone and an idle count. When an access moves away from that zone, the block holds the bus quiet for that many ticks before the next lead phase starts.

The requester raises `req` with the address, direction and write data, and holds them steady. It drops `req` in the cycle in which `ack` is seen. `ack` is high for exactly one cycle. In that cycle `rdata` holds the word that was captured at the end of the active phase.

Top module: `ext_bus_seq`

## Requirements
- R1: Configuration is written through `cfg_we`/`cfg_sel`/`cfg_wdata`.
  - When `cfg_sel[3]`=0, the word goes to the timing register of zone `cfg_sel[2:0]`. The fields are: read lead [1:0], read active [4:2], read trail [6:5], write lead [8:7], write active [11:9], write trail [13:12], doubling [14], ready enable [15], asynchronous ready mode [16].
  - When `cfg_sel[3]`=1, the word sets the global register: bank zone [2:0], idle count [5:3], half-rate timing clock [6].
  - After reset, every zone has lead 2, active 3 and trail 2 for both reads and writes, with all flags clear. The bank zone is 0, the idle count is 2 and the timing clock runs at full rate.
- R2: The zone is `req_addr[11:9]`. During an access exactly one `cs_n` bit, the one with that index, is low. `bus_addr` carries `req_addr[8:0]`.
- R3: The chip select is held low from the first lead cycle to the last trail cycle.
  - The strobe (`rd_n` for reads, `wr_n` for writes) is low only in the active phase, and the other strobe stays high.
  - Reads take the read fields and writes take the write fields.
  - For writes, `bus_wdata_oe` is high and `bus_wdata` equals the request data from lead to trail.
- R4: A lead or active count of 0 acts as 1. A trail count of 0 removes the trail phase. As a result, the strobe is never low in the first chip-select cycle.
- R5: When the doubling flag is set, the zone's lead, active and trail lengths are twice their effective counts.
- R6: When the half-rate timing clock is selected, every phase and idle length lasts twice as many system clock cycles.
- R7: With ready enabled and the mode bit clear, the active phase ends at the first timing tick at or after its programmed length in which `bus_ready` is high. With ready disabled, `bus_ready` has no effect.
- R8: With the mode bit set, `bus_ready` passes through two flops before use, so a rise takes effect two cycles later than in direct mode.
- R9: Idle ticks are inserted only when all of these hold:
  - a previous access exists;
  - the previous access went to the bank zone;
  - the new access goes to a different zone.
  
  The number of idle ticks is the idle count (0 means none). During these ticks all chip selects and strobes are high.
- R10: `ack` is high for one cycle directly after the last trail cycle (or after the last active cycle when there is no trail). In that cycle all chip selects and strobes are high. `rdata` holds the `bus_rdata` value sampled on the closing tick of the active phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | ZONE_W+1 | Zone index, or the global register when the top bit is set |
| cfg_wdata | input | CFG_W | Configuration word |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address; the top ZONE_W bits pick the zone |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| cs_n | output | 2**ZONE_W | Active-low zone chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W-ZONE_W | Address offset inside the zone |
| bus_wdata | output | DATA_W | Write data toward the bus |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Read data from the bus |
| bus_ready | input | 1 | External ready line |

## Verification
The checker verifies these properties on every cycle:
- at most one chip select is low;
- the two strobes are never low together;
- a strobe appears only inside a chip-select window, and never in its first cycle;
- the selected zone and the write data stay constant through an access;
- `ack` lasts one cycle and the bus is quiet while it is high.

Some behaviours can only be shown by the bench's scenarios, because they depend on programmed values and on stimulus timing:
- the exact lead, active and trail lengths, including the clamping of zero counts, doubling and the half-rate clock;
- how far ready stretches the active phase in each mode;
- the number of idle ticks after leaving the bank zone;
- the captured read data.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int ZONE_W = 3,
  parameter int LEAD_W = 2,
  parameter int ACT_W  = 3,
  parameter int TRL_W  = 2,
  parameter int IDLE_W = 3,
  parameter int CFG_W  = 2 * (LEAD_W + ACT_W + TRL_W) + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ZONE_W:0]          cfg_sel,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic                     req,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     ack,
  output logic [DATA_W-1:0]        rdata,
  output logic [(1<<ZONE_W)-1:0]   cs_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-ZONE_W-1:0] bus_addr,
  output logic [DATA_W-1:0]        bus_wdata,
  output logic                     bus_wdata_oe,
  input  logic [DATA_W-1:0]        bus_rdata,
  input  logic                     bus_ready
);
  localparam int NZ    = 1 << ZONE_W;
  localparam int OFS_W = ADDR_W - ZONE_W;
  localparam int CW    = ACT_W + 2;
  localparam int CNT_W = (CW > IDLE_W) ? CW : IDLE_W;
  localparam int RL_O  = 0;
  localparam int RA_O  = RL_O + LEAD_W;
  localparam int RT_O  = RA_O + ACT_W;
  localparam int WL_O  = RT_O + TRL_W;
  localparam int WA_O  = WL_O + LEAD_W;
  localparam int WT_O  = WA_O + ACT_W;
  localparam int DB_O  = WT_O + TRL_W;
  localparam int RE_O  = DB_O + 1;
  localparam int RM_O  = DB_O + 2;
  localparam int GL_W  = ZONE_W + IDLE_W + 1;
  localparam logic [CFG_W-1:0] DEF_CFG =
      (CFG_W'(2) << RL_O) | (CFG_W'(3) << RA_O) | (CFG_W'(2) << RT_O) |
      (CFG_W'(2) << WL_O) | (CFG_W'(3) << WA_O) | (CFG_W'(2) << WT_O);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LEAD, S_ACT, S_TRL, S_DONE} st_t;

  logic [CFG_W-1:0]  zcfg [NZ];
  logic [ZONE_W-1:0] bank_zone;
  logic [IDLE_W-1:0] idle_len;
  logic              div2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NZ; i++) zcfg[i] <= DEF_CFG;
      bank_zone <= '0;
      idle_len  <= IDLE_W'(2);
      div2      <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel[ZONE_W]) {div2, idle_len, bank_zone} <= cfg_wdata[GL_W-1:0];
      else                 zcfg[cfg_sel[ZONE_W-1:0]]   <= cfg_wdata;
    end
  end

  logic tick_ff, tick;
  always_ff @(posedge clk) begin
    if (!rst_n || !div2) tick_ff <= 1'b0;
    else                 tick_ff <= ~tick_ff;
  end
  assign tick = ~div2 | tick_ff;

  logic rs1, rs2;
  always_ff @(posedge clk) begin
    if (!rst_n) {rs2, rs1} <= 2'b00;
    else        {rs2, rs1} <= {rs1, bus_ready};
  end

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [CFG_W-1:0]  a_cfg;
  logic [ZONE_W-1:0] a_zone, prev_zone;
  logic              a_we, prev_valid;
  logic [OFS_W-1:0]  a_ofs;
  logic [DATA_W-1:0] a_wdata;

  logic [LEAD_W-1:0] lead_f;
  logic [ACT_W-1:0]  act_f;
  logic [TRL_W-1:0]  trl_f;
  logic [CNT_W-1:0]  lead_n, act_n, trl_n, lim;
  logic              dbl, ren, rdy_use, last, rdy_ok, need_gap;
  logic [ZONE_W-1:0] req_zone;

  assign lead_f  = a_we ? a_cfg[WL_O +: LEAD_W] : a_cfg[RL_O +: LEAD_W];
  assign act_f   = a_we ? a_cfg[WA_O +: ACT_W]  : a_cfg[RA_O +: ACT_W];
  assign trl_f   = a_we ? a_cfg[WT_O +: TRL_W]  : a_cfg[RT_O +: TRL_W];
  assign dbl     = a_cfg[DB_O];
  assign ren     = a_cfg[RE_O];
  assign rdy_use = a_cfg[RM_O] ? rs2 : bus_ready;

  assign lead_n = (lead_f == '0 ? CNT_W'(1) : CNT_W'(lead_f)) << dbl;
  assign act_n  = (act_f  == '0 ? CNT_W'(1) : CNT_W'(act_f))  << dbl;
  assign trl_n  = CNT_W'(trl_f) << dbl;

  always_comb begin
    case (st)
      S_GAP:   lim = CNT_W'(idle_len);
      S_LEAD:  lim = lead_n;
      S_ACT:   lim = act_n;
      S_TRL:   lim = trl_n;
      default: lim = CNT_W'(1);
    endcase
  end

  assign last     = (cnt == lim - CNT_W'(1));
  assign rdy_ok   = ~ren | rdy_use;
  assign req_zone = req_addr[ADDR_W-1 -: ZONE_W];
  assign need_gap = prev_valid && (prev_zone == bank_zone) &&
                    (req_zone != prev_zone) && (idle_len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      a_cfg      <= DEF_CFG;
      a_zone     <= '0;
      a_we       <= 1'b0;
      a_ofs      <= '0;
      a_wdata    <= '0;
      prev_zone  <= '0;
      prev_valid <= 1'b0;
      rdata      <= '0;
    end else if (st == S_DONE) begin
      st <= S_IDLE;
    end else if (tick) begin
      case (st)
        S_IDLE: if (req) begin
          a_cfg      <= zcfg[req_zone];
          a_zone     <= req_zone;
          a_we       <= req_we;
          a_ofs      <= req_addr[OFS_W-1:0];
          a_wdata    <= req_wdata;
          prev_zone  <= req_zone;
          prev_valid <= 1'b1;
          cnt        <= '0;
          st         <= need_gap ? S_GAP : S_LEAD;
        end
        S_GAP, S_LEAD, S_TRL: begin
          if (last) begin
            cnt <= '0;
            st  <= (st == S_GAP) ? S_LEAD : (st == S_LEAD) ? S_ACT : S_DONE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_ACT: begin
          if (!last) begin
            cnt <= cnt + CNT_W'(1);
          end else if (rdy_ok) begin
            cnt <= '0;
            if (!a_we) rdata <= bus_rdata;
            st <= (trl_n == '0) ? S_DONE : S_TRL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_bus;
  assign in_bus       = (st == S_LEAD) || (st == S_ACT) || (st == S_TRL);
  assign cs_n         = in_bus ? ~(NZ'(1) << a_zone) : '1;
  assign rd_n         = ~((st == S_ACT) && !a_we);
  assign wr_n         = ~((st == S_ACT) && a_we);
  assign bus_addr     = a_ofs;
  assign bus_wdata    = a_wdata;
  assign bus_wdata_oe = in_bus && a_we;
  assign ack          = (st == S_DONE);
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int NZ     = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NZ-1:0]     cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              bus_wdata_oe,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ack
);
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_cs_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && $past(cs_n != '1)) |-> $stable(cs_n));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (cs_n != '1));

  p_wdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wdata_oe && $past(bus_wdata_oe)) |-> $stable(bus_wdata));

  p_lead_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $past(cs_n != '1));

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_ack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((cs_n == '1) && rd_n && wr_n));
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.NZ(1 << ZONE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .bus_wdata_oe(bus_wdata_oe), .bus_wdata(bus_wdata), .ack(ack)
);

// File: tb/ext_bus_seq_tb_top.sv
`timescale 1ns/1ps
module ext_bus_seq_tb_top;
  localparam int AW = 12, DW = 16, ZW = 3, NZ = 8, CFGW = 17;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_we, req, req_we, ack, rd_n, wr_n, bus_wdata_oe, bus_ready;
  logic [ZW:0] cfg_sel;
  logic [CFGW-1:0] cfg_wdata;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rdata, bus_wdata, bus_rdata;
  logic [NZ-1:0] cs_n;
  logic [AW-ZW-1:0] bus_addr;

  int checks = 0, failures = 0;

  ext_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  typedef struct packed {
    logic [2:0] zone; logic we;
    logic [1:0] ld; logic [2:0] ac; logic [1:0] tr;
    logic dbl; logic ren; logic rm; logic div2; logic [3:0] rk;
    logic [7:0] e_ld; logic [7:0] e_ac; logic [7:0] e_tr;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{3'd1, 1'b0, 2'd2, 3'd2+3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd2, 8'd3,  8'd2},
    '{3'd2, 1'b1, 2'd1, 3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd1, 8'd1,  8'd0},
    '{3'd3, 1'b0, 2'd0, 3'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd1, 8'd4,  8'd1},
    '{3'd4, 1'b1, 2'd3, 3'd7, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'd6, 8'd14, 8'd6},
    '{3'd5, 1'b0, 2'd2, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'd2, 8'd1,  8'd2},
    '{3'd6, 1'b0, 2'd2, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'd4, 8'd4,  8'd2},
    '{3'd7, 1'b1, 2'd1, 3'd3, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 8'd4, 8'd12, 8'd8},
    '{3'd1, 1'b0, 2'd1, 3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 8'd1, 8'd5,  8'd1},
    '{3'd2, 1'b0, 2'd1, 3'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5, 8'd1, 8'd7,  8'd1},
    '{3'd3, 1'b0, 2'd1, 3'd6, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 8'd1, 8'd6,  8'd1},
    '{3'd4, 1'b1, 2'd1, 3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6, 8'd1, 8'd2,  8'd1},
    '{3'd0, 1'b0, 2'd2, 3'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'd2, 8'd3,  8'd2}
  };

  function automatic string tag_of(input int i);
    case (i)
      0:        return "R3";
      1, 2, 4:  return "R4";
      3:        return "R5";
      5, 6:     return "R6";
      8, 11:    return "R8";
      default:  return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [ZW:0] sel, input logic [CFGW-1:0] w);
    cfg_sel = sel; cfg_wdata = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [CFGW-1:0] mk_cfg(input logic [1:0] rl, input logic [2:0] ra, input logic [1:0] rt,
      input logic [1:0] wl, input logic [2:0] wa, input logic [1:0] wt, input logic dbl, input logic ren, input logic rm);
    return {rm, ren, dbl, wt, wa, wl, rt, ra, rl};
  endfunction

  function automatic logic [CFGW-1:0] mk_glob(input logic [2:0] bank, input logic [2:0] idle, input logic d2);
    return CFGW'({d2, idle, bank});
  endfunction

  task automatic access(input logic [2:0] z, input logic we, input logic [8:0] ofs, input logic [15:0] wd,
      input int rk, output int gap, output int ld, output int ac, output int tr,
      output logic [15:0] rd, output logic viol, output logic ack2);
    logic seen, got;
    gap = 0; ld = 0; ac = 0; tr = 0; viol = 1'b0; seen = 1'b0; got = 1'b0; rd = '0;
    req_addr = {z, ofs}; req_we = we; req_wdata = wd; req = 1'b1;
    if (rk > 0) bus_ready = 1'b0;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (ack) begin
        if (cs_n != '1 || !seen) viol = 1'b1;
        rd = rdata; got = 1'b1;
        break;
      end
      if (cs_n == '1) begin
        if (!rd_n || !wr_n) viol = 1'b1;
        if (!seen) gap++; else viol = 1'b1;
      end else begin
        seen = 1'b1;
        if (cs_n != ~(NZ'(1) << z)) viol = 1'b1;
        if (bus_addr != ofs) viol = 1'b1;
        if (bus_wdata_oe !== we) viol = 1'b1;
        if (we && bus_wdata !== wd) viol = 1'b1;
        if ((we ? rd_n : wr_n) == 1'b0) viol = 1'b1;
        if ((we ? wr_n : rd_n) == 1'b0) begin
          ac++;
          if (ac == rk) bus_ready = 1'b1;
        end else if (ac == 0) ld++;
        else tr++;
      end
    end
    if (!got) viol = 1'b1;
    req = 1'b0;
    @(negedge clk);
    ack2 = ack;
    bus_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap, ld, ac, tr;
    logic [15:0] rd;
    logic viol, ack2;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    bus_ready = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    check(cs_n == '1 && rd_n && wr_n && !ack && !bus_wdata_oe, "R1", "reset outputs idle",
          int'({cs_n, rd_n, wr_n, ack}), int'({8'hFF, 1'b1, 1'b1, 1'b0}));
    rst_n = 1'b1;
    @(negedge clk);

    bus_rdata = 16'h1234;
    access(3'd0, 1'b0, 9'h011, 16'h0, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(ld == 2 && ac == 3 && tr == 2, "R1", "default read phases (lead*100+act*10+trail)",
          ld*100 + ac*10 + tr, 232);
    check(gap == 0, "R9", "no idle before first access", gap, 0);
    check(rd == 16'h1234, "R10", "read data captured", int'(rd), 32'h1234);

    access(3'd1, 1'b1, 9'h0A5, 16'hBEEF, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 2, "R9", "default idle leaving bank zone 0", gap, 2);
    check(ld == 2 && ac == 3 && tr == 2, "R1", "default write phases", ld*100 + ac*10 + tr, 232);
    check(!viol, "R3", "write strobe, data and select window", int'(viol), 0);

    for (int i = 0; i < 12; i++) begin
      vec_t v;
      logic [CFGW-1:0] w;
      v = VEC[i];
      cfg_write({1'b1, 3'd0}, mk_glob(3'd0, 3'd0, v.div2));
      if (v.we) w = mk_cfg(2'd3, 3'd7, 2'd3, v.ld, v.ac, v.tr, v.dbl, v.ren, v.rm);
      else      w = mk_cfg(v.ld, v.ac, v.tr, 2'd3, 3'd7, 2'd3, v.dbl, v.ren, v.rm);
      cfg_write({1'b0, v.zone}, w);
      bus_rdata = 16'h5A00 | 16'(i);
      access(v.zone, v.we, 9'(i * 37), 16'hC000 | 16'(i), int'(v.rk), gap, ld, ac, tr, rd, viol, ack2);
      check(ld == int'(v.e_ld), tag_of(i), $sformatf("vec %0d lead", i), ld, int'(v.e_ld));
      check(ac == int'(v.e_ac), tag_of(i), $sformatf("vec %0d active", i), ac, int'(v.e_ac));
      check(tr == int'(v.e_tr), tag_of(i), $sformatf("vec %0d trail", i), tr, int'(v.e_tr));
      check(gap <= (v.div2 ? 1 : 0), "R9", $sformatf("vec %0d no idle with count 0", i), gap, 0);
      check(!viol, "R2", $sformatf("vec %0d select, address and strobes", i), int'(viol), 0);
      check(!ack2, "R10", $sformatf("vec %0d ack single cycle", i), int'(ack2), 0);
      if (!v.we) check(rd == (16'h5A00 | 16'(i)), "R10", $sformatf("vec %0d read data", i),
                       int'(rd), int'(16'h5A00 | 16'(i)));
    end

    cfg_write({1'b1, 3'd0}, mk_glob(3'd2, 3'd2, 1'b0));
    access(3'd2, 1'b0, 9'h001, 16'h0, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 0, "R9", "enter bank zone from other zone", gap, 0);
    access(3'd5, 1'b0, 9'h002, 16'h0, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 2, "R9", "leave bank zone inserts idle", gap, 2);
    check(!viol, "R9", "bus quiet during idle", int'(viol), 0);
    access(3'd2, 1'b0, 9'h003, 16'h0, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 0, "R9", "previous zone not bank", gap, 0);
    access(3'd2, 1'b1, 9'h004, 16'h1111, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 0, "R9", "same bank zone again", gap, 0);
    cfg_write({1'b1, 3'd0}, mk_glob(3'd2, 3'd5, 1'b0));
    access(3'd7, 1'b0, 9'h005, 16'h0, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 5, "R9", "idle count 5 leaving bank", gap, 5);
    cfg_write({1'b1, 3'd0}, mk_glob(3'd7, 3'd3, 1'b1));
    access(3'd6, 1'b0, 9'h006, 16'h0, 0, gap, ld, ac, tr, rd, viol, ack2);
    check(gap == 6 || gap == 7, "R6", "half-rate idle of 3 ticks", gap, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule